// File: doc/BRIEF.md
# Programmable Interrupt Priority Promoter

This block arbitrates among a set of pending maskable interrupt requests and reports the winner as the low byte of its vector address. Each request line has a fixed vector low byte. Line i maps to `VEC_BASE + 2*i`, so with the default 26 lines the vectors are the even values from $C0 up to $F2. The line with the largest vector, $F2, is the external IRQ. Without promotion, a larger vector address always beats a smaller one.

Software can lift any one source above all others. It does this by writing that source's vector low byte into an 8-bit selection register. For example, writing $F0 promotes the source whose vector sits at $FFF0. The register can be written only while the CPU interrupt-mask bit is set, and it can be read at any time. A stored value that names no implemented vector leaves the external IRQ on top, which is the same as plain fixed ordering.

The grant output is combinational from the pending lines and the register. A valid flag qualifies it. The CPU stacking sequence and the vector fetch belong to the consumer.

Top module: `prio_promoter`

## Requirements
- R1: After reset the selection register reads $F2, so the IRQ (line NSRC-1) is the promoted source.
- R2: A write with `wr_en`=1 and `i_mask`=1 stores `wr_data[5:1]`. From the next clock edge `rd_data` reads {2'b11, stored bits, 1'b0}: bits 7 and 6 always read 1 and bit 0 always reads 0.
- R3: A write with `i_mask`=0 leaves `rd_data` and the arbitration order unchanged.
- R4: When the line whose vector equals `rd_data` is pending, `grant_vec` equals `rd_data`, whatever other lines are pending.
- R5: When the promoted line is not pending, `grant_vec` is `VEC_BASE + 2*i` for the highest-index pending line i.
- R6: When `rd_data` is above the top implemented vector ($F4 to $FE by default), the IRQ line is the promoted source.
- R7: With no line pending, `grant_valid` is 0 and `grant_vec` is $00. Otherwise `grant_valid` is 1.
- R8: The grant follows `pend` in the same cycle. A register write made in a cycle affects the grant only after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Vector low byte to promote |
| i_mask | input | 1 | CPU interrupt-mask bit; writes are accepted only when 1 |
| rd_data | output | 8 | Register read value |
| pend | input | NSRC | Pending maskable requests; line i has vector VEC_BASE+2*i |
| grant_vec | output | 8 | Vector low byte of the winning request |
| grant_valid | output | 1 | At least one request is pending |

## Verification
A register write and an arbitration decision can fall in the same cycle. The grant then has to be judged against the old promotion before the clock edge and against the new one after it. The bench provokes this by driving a write together with a pending pattern in which both the old and the new promoted lines are pending. It checks `grant_vec` just before the edge and again just after it. The remaining checks sweep every writable register value against single-line, full and pseudo-random pending patterns, with the expected winner computed arithmetically.

// File: rtl/prio_promoter.sv
module prio_promoter #(
  parameter int         NSRC      = 26,
  parameter logic [7:0] VEC_BASE  = 8'hC0,
  parameter logic [7:0] RESET_VEC = 8'hF2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [7:0]      wr_data,
  input  logic            i_mask,
  output logic [7:0]      rd_data,
  input  logic [NSRC-1:0] pend,
  output logic [7:0]      grant_vec,
  output logic            grant_valid
);
  localparam logic [7:0] TOP_VEC = VEC_BASE + 8'(2 * (NSRC - 1));
  localparam int         IW      = (NSRC > 1) ? $clog2(NSRC) : 1;

  logic [4:0]    sel_q;
  logic [7:0]    offs;
  logic          in_range;
  logic [IW-1:0] prom_idx;
  logic [IW-1:0] fix_idx;
  logic [IW-1:0] win_idx;
  logic          unused_ok;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                sel_q <= RESET_VEC[5:1];
    else if (wr_en && i_mask)  sel_q <= wr_data[5:1];

  assign rd_data  = {2'b11, sel_q, 1'b0};
  assign offs     = rd_data - VEC_BASE;
  assign in_range = (rd_data >= VEC_BASE) && (rd_data <= TOP_VEC);
  assign prom_idx = in_range ? IW'(offs[7:1]) : IW'(NSRC - 1);

  always_comb begin
    fix_idx = '0;
    for (int i = 0; i < NSRC; i++)
      if (pend[i]) fix_idx = IW'(i);
  end

  assign win_idx     = pend[prom_idx] ? prom_idx : fix_idx;
  assign grant_valid = |pend;
  assign grant_vec   = grant_valid ? VEC_BASE + 8'({win_idx, 1'b0}) : 8'h00;

  assign unused_ok = ^{wr_data[7:6], wr_data[0], offs[0]};

  p_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && i_mask) |=> rd_data == {2'b11, $past(wr_data[5:1]), 1'b0});

  p_masked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !i_mask) |=> $stable(rd_data));

  p_promoted_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_range && pend[prom_idx]) |-> grant_vec == rd_data);

  p_granted_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> pend[IW'((grant_vec - VEC_BASE) >> 1)]);

  p_fallback_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data > TOP_VEC && pend[NSRC-1]) |-> grant_vec == TOP_VEC);

  p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == '0) |-> (!grant_valid && grant_vec == 8'h00));
endmodule

// File: tb/tb_prio_promoter.sv
`timescale 1ns/1ps
module tb_prio_promoter;
  localparam int N = 26;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [7:0]   wr_data = 8'h00;
  logic         i_mask = 1'b0;
  logic [7:0]   rd_data;
  logic [N-1:0] pend = '0;
  logic [7:0]   grant_vec;
  logic         grant_valid;

  int checks = 0;
  int errors = 0;
  logic [31:0] lfsr = 32'h1234_5678;

  always #2.5 clk = ~clk;

  prio_promoter dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .i_mask(i_mask),
    .rd_data(rd_data), .pend(pend), .grant_vec(grant_vec), .grant_valid(grant_valid)
  );

  function automatic logic [7:0] exp_grant(input logic [7:0] regv, input logic [N-1:0] p);
    logic [7:0] pv;
    int pi;
    pv = (regv <= 8'hF2) ? regv : 8'hF2;
    pi = (int'(pv) - 'hC0) / 2;
    if (p[pi]) return pv;
    for (int i = N - 1; i >= 0; i--)
      if (p[i]) return 8'(8'hC0 + 2 * i);
    return 8'h00;
  endfunction

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] d, input logic m);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d; i_mask = m;
    @(negedge clk);
    wr_en = 1'b0; i_mask = 1'b0;
  endtask

  task automatic try_pattern(input logic [7:0] regv, input logic [N-1:0] p);
    logic [7:0] e;
    int pi;
    pend = p;
    #1;
    e = exp_grant(regv, p);
    pi = (int'((regv <= 8'hF2) ? regv : 8'hF2) - 'hC0) / 2;
    if (p == '0) begin
      check8("R7 valid", {7'd0, grant_valid}, 8'd0);
      check8("R7 vec", grant_vec, 8'h00);
    end else begin
      check8("R7 valid", {7'd0, grant_valid}, 8'd1);
      if (regv > 8'hF2)   check8("R6 fallback", grant_vec, e);
      else if (p[pi])     check8("R4 promoted", grant_vec, e);
      else                check8("R5 fixed", grant_vec, e);
    end
  endtask

  task automatic next_rand;
    lfsr = lfsr ^ (lfsr << 13);
    lfsr = lfsr ^ (lfsr >> 17);
    lfsr = lfsr ^ (lfsr << 5);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] regv;
    #12 rst_n = 1'b1;
    @(negedge clk);
    check8("R1 reset", rd_data, 8'hF2);
    try_pattern(8'hF2, {N{1'b1}});
    try_pattern(8'hF2, 26'h1);

    for (int v = 0; v < 32; v++) begin
      regv = {2'b11, 5'(v), 1'b0};
      do_write({~regv[7:6], 5'(v), 1'b1}, 1'b1);
      check8("R2 write", rd_data, regv);
      try_pattern(regv, '0);
      try_pattern(regv, {N{1'b1}});
      for (int i = 0; i < N; i++) try_pattern(regv, N'(1) << i);
      for (int k = 0; k < 6; k++) begin
        next_rand;
        try_pattern(regv, lfsr[N-1:0]);
        try_pattern(regv, lfsr[N-1:0] & ~(N'(1) << ((int'(regv) - 'hC0) / 2 % N)));
      end
      do_write(8'hC4, 1'b0);
      check8("R3 masked", rd_data, regv);
      try_pattern(regv, 26'h5);
    end

    do_write(8'hF0, 1'b1);
    @(negedge clk);
    pend = (N'(1) << 24) | (N'(1) << 2);
    wr_en = 1'b1; wr_data = 8'hC4; i_mask = 1'b1;
    #1 check8("R8 before edge", grant_vec, 8'hF0);
    @(posedge clk); #1;
    wr_en = 1'b0; i_mask = 1'b0;
    check8("R8 after edge", grant_vec, 8'hC4);
    pend = N'(1) << 24;
    #1 check8("R8 comb follow", grant_vec, 8'hF0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule